// File: doc/BRIEF.md
# Receive Link Health Monitor with Per-Bit Default Substitution

This block sits behind the message decoder of a serial protection-signalling receiver. Each cycle it gets the decoder's view of the channel: a strobe for each decoded message with its eight data bits and the sender ID carried in the message, error flags from the serial receiver (parity, framing and overrun), a flag that says word synchronization has been found, the enable and loopback controls, a mode select, and a tick once per transmit-message period. From these it decides whether the channel can be trusted. The result is a single receive-OK bit.

The eight output bits go to downstream security filtering. While the link is healthy they follow the data of the most recent accepted message. While it is unhealthy each bit takes the value picked by its own two-bit default code: a constant 0, a constant 1, or the last value that was received validly. Health comes back only after a fresh synchronization report followed by two clean messages in a row. The missing-message timeout is three transmit periods in the standard mode and seven in the alternate mode.

Top module: `rx_link_guard`

## Requirements
- R1: `rxOk` is 0 in the cycle after any cycle in which `blockEn` is 0, `protoEn` is 0 or `loopbackEn` is 1.
- R2: `rxOk` is 0 in the cycle after any cycle in which `parityErr`, `frameErr` or `overrunErr` is 1.
- R3: A message strobe (`msgValid`=1) whose `msgId` differs from `expectId` makes `rxOk` 0 in the next cycle.
- R4: Every accepted message restarts the timeout count. If `periodTick` pulses 3 times (with `altMode`=0) or 7 times (with `altMode`=1) and no accepted message arrives in between, `rxOk` is 0 one cycle after the clock edge that captures the last of those ticks. One tick fewer leaves `rxOk` high.
- R5: `rxOk` rises only on the clock edge that captures the second of two consecutive accepted messages after a rising edge of `syncOk`. After the first of them, `rxOk` is still 0.
- R6: While `rxOk` is 1, `rxBits` equals the data of the most recent accepted message, visible from the cycle after its capture edge.
- R7: While `rxOk` is 0, output bit b is chosen by `dfltMask[2b+1:2b]`: 00 gives 0, 01 gives 1, 10 or 11 gives the stored last-valid value of bit b.
- R8: The stored last-valid values change only on an accepted message while `rxOk` is 1, or on the message that raises `rxOk`. Messages received while unhealthy, including the first message after synchronization, leave them unchanged.
- R9: Any fault (R1–R4 conditions, or `syncOk` low) clears the count of good messages. Counting does not resume until `syncOk` has gone low and then high again, so clean messages with `syncOk` held high do not restore `rxOk`.
- R10: After reset `rxOk` is 0 and every stored last-valid value is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| blockEn | input | 1 | Block enable |
| protoEn | input | 1 | Signalling protocol enable |
| loopbackEn | input | 1 | Loopback test mode (forces unhealthy) |
| altMode | input | 1 | 0: 3-period timeout, 1: 7-period timeout |
| syncOk | input | 1 | Word synchronization found (level) |
| periodTick | input | 1 | One pulse per transmit-message period |
| msgValid | input | 1 | Decoded message strobe |
| msgData | input | NBITS | Data bits of the decoded message |
| msgId | input | ID_W | Sender ID carried in the message |
| expectId | input | ID_W | Configured expected ID |
| parityErr | input | 1 | Parity error pulse |
| frameErr | input | 1 | Framing error pulse |
| overrunErr | input | 1 | Overrun error pulse |
| dfltMask | input | 2*NBITS | Per-bit default code, bits [2b+1:2b] for bit b |
| rxOk | output | 1 | Link healthy |
| rxBits | output | NBITS | Received or substituted data bits |

## Verification
The pass-through path is driven with all 256 data values on a healthy link, so a dropped or swapped bit cannot go unseen. The ID check is driven with every 3-bit ID against a fixed expected ID, which separates an exact compare from a partial one. For the default path, 64 mask patterns that mix all four codes across the bits are applied over two different held words. This shows whether the decode looks at the right pair and treats 10 and 11 the same. Timeouts are tested one tick short of and exactly at the limit in both modes. Recovery is tested with sync held high and then with sync re-reported, which shows whether the good-message count restarts only on a fresh sync.

// File: rtl/rx_link_pkg.sv
package rx_link_pkg;
  typedef struct packed {
    logic clrTick;
    logic incTick;
    logic latchData;
  } ctlStrobe_t;
endpackage

// File: rtl/rx_link_ctrl.sv
module rx_link_ctrl
  import rx_link_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       blockEn,
  input  logic       protoEn,
  input  logic       loopbackEn,
  input  logic       syncOk,
  input  logic       periodTick,
  input  logic       msgValid,
  input  logic       parityErr,
  input  logic       frameErr,
  input  logic       overrunErr,
  input  logic       idMatch,
  input  logic       tmo,
  output logic       rxOk,
  output ctlStrobe_t strb
);
  localparam int GOOD_W = 2;

  logic              syncPrev;
  logic              armed;
  logic [GOOD_W-1:0] goodCnt;
  logic              enabled;
  logic              errAny;
  logic              fault;
  logic              goodMsg;
  logic              syncRise;
  logic              qualify;

  assign enabled  = blockEn & protoEn & ~loopbackEn;
  assign errAny   = parityErr | frameErr | overrunErr;
  assign fault    = ~enabled | ~syncOk | errAny | (msgValid & ~idMatch) | tmo;
  assign goodMsg  = msgValid & idMatch & ~fault & armed;
  assign syncRise = syncOk & ~syncPrev;
  assign qualify  = goodMsg & (rxOk | (goodCnt == GOOD_W'(1)));

  always_comb begin
    strb.clrTick   = fault | ~armed | goodMsg;
    strb.incTick   = armed & ~fault & ~goodMsg & periodTick;
    strb.latchData = qualify;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncPrev <= 1'b0;
      armed    <= 1'b0;
      goodCnt  <= '0;
      rxOk     <= 1'b0;
    end else begin
      syncPrev <= syncOk;
      if (fault) begin
        armed   <= 1'b0;
        goodCnt <= '0;
        rxOk    <= 1'b0;
      end else begin
        if (syncRise) armed <= 1'b1;
        if (goodMsg) begin
          if (goodCnt != GOOD_W'(2)) goodCnt <= goodCnt + GOOD_W'(1);
          if (goodCnt == GOOD_W'(1)) rxOk <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/rx_link_dpath.sv
module rx_link_dpath
  import rx_link_pkg::*;
#(
  parameter int NBITS   = 8,
  parameter int ID_W    = 3,
  parameter int LIM_STD = 3,
  parameter int LIM_ALT = 7
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               altMode,
  input  logic [NBITS-1:0]   msgData,
  input  logic [ID_W-1:0]    msgId,
  input  logic [ID_W-1:0]    expectId,
  input  logic [2*NBITS-1:0] dfltMask,
  input  logic               rxOk,
  input  ctlStrobe_t         strb,
  output logic               idMatch,
  output logic               tmo,
  output logic [NBITS-1:0]   rxBits
);
  localparam int LIM_MAX = (LIM_ALT > LIM_STD) ? LIM_ALT : LIM_STD;
  localparam int CNT_W   = $clog2(LIM_MAX + 1);

  logic [CNT_W-1:0] tickCnt;
  logic [CNT_W-1:0] limit;
  logic [NBITS-1:0] lastValid;

  assign idMatch = (msgId == expectId);
  assign limit   = altMode ? CNT_W'(LIM_ALT) : CNT_W'(LIM_STD);
  assign tmo     = (tickCnt >= limit);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tickCnt <= '0;
    end else if (strb.clrTick) begin
      tickCnt <= '0;
    end else if (strb.incTick && !tmo) begin
      tickCnt <= tickCnt + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) lastValid <= '0;
    else if (strb.latchData) lastValid <= msgData;
  end

  for (genvar b = 0; b < NBITS; b++) begin : g_bit
    logic [1:0] code;
    assign code = dfltMask[2*b +: 2];
    always_comb begin
      if (rxOk)         rxBits[b] = lastValid[b];
      else if (code[1]) rxBits[b] = lastValid[b];
      else              rxBits[b] = code[0];
    end
  end
endmodule

// File: rtl/rx_link_guard.sv
module rx_link_guard
  import rx_link_pkg::*;
#(
  parameter int NBITS   = 8,
  parameter int ID_W    = 3,
  parameter int LIM_STD = 3,
  parameter int LIM_ALT = 7
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               blockEn,
  input  logic               protoEn,
  input  logic               loopbackEn,
  input  logic               altMode,
  input  logic               syncOk,
  input  logic               periodTick,
  input  logic               msgValid,
  input  logic [NBITS-1:0]   msgData,
  input  logic [ID_W-1:0]    msgId,
  input  logic [ID_W-1:0]    expectId,
  input  logic               parityErr,
  input  logic               frameErr,
  input  logic               overrunErr,
  input  logic [2*NBITS-1:0] dfltMask,
  output logic               rxOk,
  output logic [NBITS-1:0]   rxBits
);
  ctlStrobe_t strb;
  logic       idMatch;
  logic       tmo;

  rx_link_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .blockEn(blockEn), .protoEn(protoEn),
    .loopbackEn(loopbackEn), .syncOk(syncOk), .periodTick(periodTick),
    .msgValid(msgValid), .parityErr(parityErr), .frameErr(frameErr),
    .overrunErr(overrunErr), .idMatch(idMatch), .tmo(tmo),
    .rxOk(rxOk), .strb(strb)
  );

  rx_link_dpath #(
    .NBITS(NBITS), .ID_W(ID_W), .LIM_STD(LIM_STD), .LIM_ALT(LIM_ALT)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .altMode(altMode), .msgData(msgData),
    .msgId(msgId), .expectId(expectId), .dfltMask(dfltMask),
    .rxOk(rxOk), .strb(strb), .idMatch(idMatch), .tmo(tmo), .rxBits(rxBits)
  );
endmodule

// File: rtl/rx_link_guard_chk.sv
module rx_link_guard_chk #(
  parameter int NBITS = 8,
  parameter int ID_W  = 3
) (
  input logic               clk,
  input logic               rstN,
  input logic               blockEn,
  input logic               protoEn,
  input logic               loopbackEn,
  input logic               syncOk,
  input logic               msgValid,
  input logic [ID_W-1:0]    msgId,
  input logic [ID_W-1:0]    expectId,
  input logic               parityErr,
  input logic               frameErr,
  input logic               overrunErr,
  input logic [2*NBITS-1:0] dfltMask,
  input logic               rxOk,
  input logic [NBITS-1:0]   rxBits
);
  // R1
  disabled_drops_ok_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!blockEn || !protoEn || loopbackEn) |=> !rxOk);

  // R2
  line_err_drops_ok_chk: assert property (@(posedge clk) disable iff (!rstN)
    (parityErr || frameErr || overrunErr) |=> !rxOk);

  // R3
  id_mismatch_drops_ok_chk: assert property (@(posedge clk) disable iff (!rstN)
    (msgValid && (msgId != expectId)) |=> !rxOk);

  // R5
  ok_rise_on_msg_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxOk) |-> $past(msgValid && (msgId == expectId) && syncOk));

  // R8
  healthy_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rxOk && $past(rxOk) && !$past(msgValid)) |-> $stable(rxBits));

  for (genvar b = 0; b < NBITS; b++) begin : g_chk
    // R7
    force_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
      (!rxOk && dfltMask[2*b +: 2] == 2'b00) |-> !rxBits[b]);
    // R7
    force_one_chk: assert property (@(posedge clk) disable iff (!rstN)
      (!rxOk && dfltMask[2*b +: 2] == 2'b01) |-> rxBits[b]);
  end
endmodule

bind rx_link_guard rx_link_guard_chk #(.NBITS(NBITS), .ID_W(ID_W)) u_chk (
  .clk(clk), .rstN(rstN), .blockEn(blockEn), .protoEn(protoEn),
  .loopbackEn(loopbackEn), .syncOk(syncOk), .msgValid(msgValid),
  .msgId(msgId), .expectId(expectId), .parityErr(parityErr),
  .frameErr(frameErr), .overrunErr(overrunErr), .dfltMask(dfltMask),
  .rxOk(rxOk), .rxBits(rxBits)
);

// File: tb/rx_link_guard_tb.sv
`timescale 1ns/1ps
module rx_link_guard_tb;
  localparam int NBITS = 8;
  localparam int ID_W  = 3;
  localparam logic [ID_W-1:0] EXP_ID = 3'd5;

  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic               blockEn = 1'b0, protoEn = 1'b0, loopbackEn = 1'b0;
  logic               altMode = 1'b0, syncOk = 1'b0, periodTick = 1'b0;
  logic               msgValid = 1'b0;
  logic [NBITS-1:0]   msgData = '0;
  logic [ID_W-1:0]    msgId = '0;
  logic [ID_W-1:0]    expectId = EXP_ID;
  logic               parityErr = 1'b0, frameErr = 1'b0, overrunErr = 1'b0;
  logic [2*NBITS-1:0] dfltMask = '0;
  logic               rxOk;
  logic [NBITS-1:0]   rxBits;

  int nChk = 0;
  int nBad = 0;

  always #2.5 clk = ~clk;

  rx_link_guard #(.NBITS(NBITS), .ID_W(ID_W)) u_dut (
    .clk(clk), .rstN(rstN), .blockEn(blockEn), .protoEn(protoEn),
    .loopbackEn(loopbackEn), .altMode(altMode), .syncOk(syncOk),
    .periodTick(periodTick), .msgValid(msgValid), .msgData(msgData),
    .msgId(msgId), .expectId(expectId), .parityErr(parityErr),
    .frameErr(frameErr), .overrunErr(overrunErr), .dfltMask(dfltMask),
    .rxOk(rxOk), .rxBits(rxBits)
  );

  task automatic check(input string req, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic sendMsg(input logic [NBITS-1:0] d, input logic [ID_W-1:0] id);
    msgValid = 1'b1; msgData = d; msgId = id;
    step();
    msgValid = 1'b0;
  endtask

  task automatic tickOnce();
    periodTick = 1'b1;
    step();
    periodTick = 1'b0;
  endtask

  task automatic bringUp(input logic [NBITS-1:0] d0, input logic [NBITS-1:0] d1);
    blockEn = 1'b1; protoEn = 1'b1; loopbackEn = 1'b0;
    syncOk = 1'b0; step();
    syncOk = 1'b1; step();
    sendMsg(d0, EXP_ID);
    sendMsg(d1, EXP_ID);
  endtask

  function automatic logic [NBITS-1:0] subst(input logic [2*NBITS-1:0] m,
                                             input logic [NBITS-1:0] held);
    logic [NBITS-1:0] r;
    for (int b = 0; b < NBITS; b++)
      r[b] = m[2*b+1] ? held[b] : m[2*b];
    return r;
  endfunction

  initial begin
    #(100000 * 5);
    nBad++;
    $display("FAIL watchdog: actual running expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    step(); step();
    // R10: reset state
    check("R10 rxOk", int'(rxOk), 0);
    dfltMask = {NBITS{2'b10}};
    step();
    check("R10 lastValid", int'(rxBits), 0);
    rstN = 1'b1;
    step();

    // R5: first message does not raise, second does
    blockEn = 1'b1; protoEn = 1'b1;
    syncOk = 1'b0; step(); syncOk = 1'b1; step();
    sendMsg(8'hA5, EXP_ID);
    check("R5 after first", int'(rxOk), 0);
    // R8: first message not stored
    check("R8 first not stored", int'(rxBits), 0);
    sendMsg(8'h3C, EXP_ID);
    check("R5 after second", int'(rxOk), 1);
    check("R6 second data", int'(rxBits), 'h3C);

    // R6: all data values pass through
    for (int v = 0; v < 256; v++) begin
      sendMsg(NBITS'(v), EXP_ID);
      check("R6 pass", int'(rxBits), v);
      check("R6 ok", int'(rxOk), 1);
    end

    // R3: every ID against expected
    for (int i = 0; i < 8; i++) begin
      bringUp(8'h11, 8'h22);
      sendMsg(8'h77, ID_W'(i));
      check("R3 id", int'(rxOk), (i == int'(EXP_ID)) ? 1 : 0);
    end

    // R2: each line error
    for (int e = 0; e < 3; e++) begin
      bringUp(8'h01, 8'h02);
      parityErr = (e == 0); frameErr = (e == 1); overrunErr = (e == 2);
      step();
      parityErr = 1'b0; frameErr = 1'b0; overrunErr = 1'b0;
      check("R2 err", int'(rxOk), 0);
    end

    // R1: disable, protocol off, loopback
    for (int k = 0; k < 3; k++) begin
      bringUp(8'h0F, 8'hF0);
      blockEn = (k != 0); protoEn = (k != 1); loopbackEn = (k == 2);
      step();
      check("R1 ctrl", int'(rxOk), 0);
      blockEn = 1'b1; protoEn = 1'b1; loopbackEn = 1'b0;
    end

    // R4: timeout in both modes
    for (int md = 0; md < 2; md++) begin
      int lim;
      lim = (md == 0) ? 3 : 7;
      altMode = logic'(md);
      bringUp(8'h55, 8'hAA);
      for (int t = 0; t < lim - 1; t++) tickOnce();
      step();
      check("R4 below limit", int'(rxOk), 1);
      sendMsg(8'h5A, EXP_ID);
      for (int t = 0; t < lim - 1; t++) tickOnce();
      step();
      check("R4 restart by message", int'(rxOk), 1);
      tickOnce();
      step();
      check("R4 at limit", int'(rxOk), 0);
    end
    altMode = 1'b0;

    // R9: no recovery without a fresh sync report
    bringUp(8'h12, 8'h34);
    parityErr = 1'b1; step(); parityErr = 1'b0;
    sendMsg(8'h56, EXP_ID);
    sendMsg(8'h78, EXP_ID);
    step();
    check("R9 no resync", int'(rxOk), 0);
    bringUp(8'h9A, 8'hBC);
    check("R9 resync", int'(rxOk), 1);

    // R7 / R8: substitution with two held words
    for (int w = 0; w < 2; w++) begin
      logic [NBITS-1:0] held;
      held = (w == 0) ? 8'hC3 : 8'h5A;
      bringUp(~held, held);
      loopbackEn = 1'b1; step();
      // R8: message while unhealthy must not change the stored word
      sendMsg(~held, EXP_ID);
      for (int i = 0; i < 64; i++) begin
        logic [2*NBITS-1:0] m;
        for (int b = 0; b < NBITS; b++)
          m[2*b +: 2] = 2'((i * 5 + b * 3 + (i >> 3)) % 4);
        dfltMask = m;
        step();
        check("R7 subst", int'(rxBits), int'(subst(m, held)));
      end
      dfltMask = {NBITS{2'b11}};
      step();
      check("R8 held intact", int'(rxBits), int'(held));
      loopbackEn = 1'b0;
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule